// File: doc/BRIEF.md
# Segmented Virtual-to-Physical Address Relocation Unit

This block turns a 16-bit virtual address from a minicomputer-style processor into a 22-bit physical address. The top three bits of the virtual address pick one of eight segments. Each segment has a base register and a descriptor register. A separate set of both exists for every processor mode (kernel, supervisor, user) and for instruction space and data space. The base register, shifted left by six bits, is added to the 13-bit offset inside the segment.

Two small status/configuration words control the translation. The control word holds the relocation enable, three abort flags, a trap flag and a trap enable. The extension word selects 22-bit or 18-bit physical addressing, enables separate data space per mode, and holds a bus-map enable. Both words are cleared by a bus-reset pulse. All registers sit on a simple synchronous register bus: an 8-bit address, a write strobe and combinational read data.

Translation itself is combinational from virtual address, mode and the data/instruction select. It also raises a fault flag when the selected descriptor marks its segment as not present.

Top module: `seg_reloc_unit`

## Requirements
- R1: The control word (register address 0x80) stores bits 0 (relocation enable), 1 (trap enable), 2 (trap flag), 3 (read-only abort), 4 (length abort) and 5 (non-resident abort) from a write. Bit 7 reads the `instrDone` input whatever was written, and bits 6 and 8-15 read zero.
- R2: The extension word (address 0x81) stores bit 0 (user data space), 1 (supervisor data space), 2 (kernel data space), 3 (22-bit mode) and 4 (bus-map enable), and bits 5-15 read zero.
- R3: A one-cycle `busReset` pulse clears every stored bit of both words. Base and descriptor registers keep their contents.
- R4: Addresses 0x00-0x7F hold the base (bit 6 = 0) and descriptor (bit 6 = 1) registers. Bits 5:4 give the mode (0 kernel, 1 supervisor, 3 user), bit 3 selects data space and bits 2:0 the segment. Every one reads back what was last written.
- R5: With relocation disabled, a virtual address below 0xE000 appears unchanged (zero-extended). An address at or above 0xE000 goes to 0x3FE000 plus its low 13 bits.
- R6: With relocation enabled, the physical address is the selected base register times 64 plus virtual bits 12:0. With base registers set to segment × 0x80, segments 0-6 give a physical address equal to the virtual one.
- R7: In 18-bit mode (extension bit 3 = 0), bits 15:12 of the base register have no effect on the physical address.
- R8: In 18-bit mode, a relocated sum at or above 0x3E000 is moved up by 0x3C0000, onto the I/O page at the top of the 22-bit space.
- R9: In 22-bit mode, the full 16-bit base register is used and the sum is taken modulo 2^22.
- R10: A data reference (`isData` = 1) uses the data-space register set only when that mode's data-space enable is set. Instruction references always use the instruction set.
- R11: `accessFault` is 1 exactly when relocation is enabled and bits 2:1 of the selected descriptor are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, clears every register |
| busReset | input | 1 | Synchronous pulse clearing the control and extension words |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` (combinational) |
| instrDone | input | 1 | Instruction-complete status shown in control bit 7 |
| virtAddr | input | 16 | Virtual address to translate |
| cpuMode | input | 2 | Access mode: 0 kernel, 1 supervisor, 3 user |
| isData | input | 1 | 1 for a data reference, 0 for an instruction fetch |
| physAddr | output | 22 | Translated physical address |
| accessFault | output | 1 | Selected segment marked not present |

## Verification
The bench builds the unit with its default parameters: 16-bit virtual addresses, a 16-bit register bus, 22-bit physical and 18-bit narrow spaces. It can therefore sweep every control and extension bit pattern, all 64 base and descriptor slots, and all 16 combinations of the three data-space enables with the width mode. Virtual addresses are sampled evenly across all eight segments. This brings in reach the I/O-page folds of both the unrelocated and the 18-bit paths, the wrap of the 22-bit sum, and data-versus-instruction selection in every mode.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  localparam int SEG_W  = 3;
  localparam int MODE_W = 2;
  localparam int IDX_W  = MODE_W + 1 + SEG_W;
  localparam int NSLOT  = 1 << IDX_W;
  localparam int ADDR_W = IDX_W + 2;

  localparam int C0_W      = 6;
  localparam int C0_EN     = 0;
  localparam int C3_W      = 5;
  localparam int C3_DUSR   = 0;
  localparam int C3_DSUP   = 1;
  localparam int C3_DKRN   = 2;
  localparam int C3_WIDE   = 3;

  localparam int PDR_ACC_LO = 1;
  localparam int PDR_ACC_HI = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_USER = 2'd3
  } cpuMode_e;

  typedef struct packed {
    logic             wrPar;
    logic             wrPdr;
    logic [IDX_W-1:0] idx;
  } tableCmd_t;

  typedef struct packed {
    logic       relocOn;
    logic       wide22;
    logic [3:0] dSpaceEn;
  } xlateCfg_t;
endpackage

// File: rtl/reloc_ctl.sv
module reloc_ctl
  import reloc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busReset,
  input  logic                   regWr,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [C0_W-1:0]        wrBits,
  input  logic                   instrDone,
  input  logic [DATA_W-1:0]      parRd,
  input  logic [DATA_W-1:0]      pdrRd,
  output logic [DATA_W-1:0]      regRdData,
  output tableCmd_t              cmd,
  output xlateCfg_t              cfg
);
  logic [C0_W-1:0] ctl0;
  logic [C3_W-1:0] ctl3;
  logic isStat, selC3, isPdr;

  assign isStat = regAddr[ADDR_W-1];
  assign isPdr  = regAddr[ADDR_W-2];
  assign selC3  = regAddr[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl0 <= '0;
      ctl3 <= '0;
    end else if (busReset) begin
      ctl0 <= '0;
      ctl3 <= '0;
    end else if (regWr && isStat) begin
      if (selC3) ctl3 <= wrBits[C3_W-1:0];
      else       ctl0 <= wrBits;
    end
  end

  always_comb begin
    cmd.wrPar = regWr & ~isStat & ~isPdr;
    cmd.wrPdr = regWr & ~isStat & isPdr;
    cmd.idx   = regAddr[IDX_W-1:0];
  end

  always_comb begin
    cfg.relocOn  = ctl0[C0_EN];
    cfg.wide22   = ctl3[C3_WIDE];
    cfg.dSpaceEn = {ctl3[C3_DUSR], 1'b0, ctl3[C3_DSUP], ctl3[C3_DKRN]};
  end

  always_comb begin
    if (isStat) begin
      if (selC3) regRdData = DATA_W'(ctl3);
      else       regRdData = DATA_W'({instrDone, 1'b0, ctl0});
    end else begin
      regRdData = isPdr ? pdrRd : parRd;
    end
  end

  assert_bus_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (ctl0 == '0 && ctl3 == '0));

  assert_ext_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && isStat && selC3 && !busReset) |=> ctl3 == $past(wrBits[C3_W-1:0]));
endmodule

// File: rtl/reloc_dp.sv
module reloc_dp
  import reloc_pkg::*;
#(
  parameter int VA_W     = 16,
  parameter int DATA_W   = 16,
  parameter int PA_W     = 22,
  parameter int NARROW_W = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  tableCmd_t           cmd,
  input  logic [DATA_W-1:0]   wrData,
  input  xlateCfg_t           cfg,
  input  logic [VA_W-1:0]     virtAddr,
  input  logic [MODE_W-1:0]   cpuMode,
  input  logic                isData,
  output logic [DATA_W-1:0]   parRd,
  output logic [DATA_W-1:0]   pdrRd,
  output logic [PA_W-1:0]     physAddr,
  output logic                accessFault
);
  localparam int OFF_W   = VA_W - SEG_W;
  localparam int PAGE_SH = PA_W - DATA_W;
  localparam int KEEP_W  = NARROW_W - PAGE_SH;
  localparam int HI_W    = PA_W - NARROW_W;

  logic [DATA_W-1:0] parTbl [NSLOT];
  logic [DATA_W-1:0] pdrTbl [NSLOT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSLOT; i++) begin
        parTbl[i] <= '0;
        pdrTbl[i] <= '0;
      end
    end else begin
      if (cmd.wrPar) parTbl[cmd.idx] <= wrData;
      if (cmd.wrPdr) pdrTbl[cmd.idx] <= wrData;
    end
  end

  assign parRd = parTbl[cmd.idx];
  assign pdrRd = pdrTbl[cmd.idx];

  logic [SEG_W-1:0]  seg;
  logic [OFF_W-1:0]  off;
  logic              useD;
  logic [IDX_W-1:0]  xIdx;
  logic [DATA_W-1:0] parSel, parEff;
  logic [1:0]        pdrAcc;
  logic [PA_W-1:0]   relSum, relocated, plain;
  logic              narrowIo, vaIo;

  always_comb begin
    seg    = virtAddr[VA_W-1 -: SEG_W];
    off    = virtAddr[OFF_W-1:0];
    useD   = isData & cfg.dSpaceEn[cpuMode];
    xIdx   = {cpuMode, useD, seg};
    parSel = parTbl[xIdx];
    pdrAcc = pdrTbl[xIdx][PDR_ACC_HI:PDR_ACC_LO];
    parEff = cfg.wide22 ? parSel : {{(DATA_W-KEEP_W){1'b0}}, parSel[KEEP_W-1:0]};
    relSum = {parEff, {PAGE_SH{1'b0}}} + {{(PA_W-OFF_W){1'b0}}, off};
    narrowIo = &relSum[NARROW_W-1:OFF_W];
    if (cfg.wide22)    relocated = relSum;
    else if (narrowIo) relocated = {{HI_W{1'b1}}, relSum[NARROW_W-1:0]};
    else               relocated = {{HI_W{1'b0}}, relSum[NARROW_W-1:0]};
    vaIo  = &virtAddr[VA_W-1:OFF_W];
    plain = vaIo ? {{(PA_W-OFF_W){1'b1}}, off} : {{(PA_W-VA_W){1'b0}}, virtAddr};
    physAddr    = cfg.relocOn ? relocated : plain;
    accessFault = cfg.relocOn & ~|pdrAcc;
  end

  assert_plain_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.relocOn && !(&virtAddr[VA_W-1:OFF_W])) |->
      physAddr == {{(PA_W-VA_W){1'b0}}, virtAddr});

  assert_narrow_io_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.relocOn && !cfg.wide22 && |physAddr[PA_W-1:NARROW_W]) |->
      &physAddr[NARROW_W-1:OFF_W]);
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
  import reloc_pkg::*;
#(
  parameter int VA_W     = 16,
  parameter int DATA_W   = 16,
  parameter int PA_W     = 22,
  parameter int NARROW_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              instrDone,
  input  logic [VA_W-1:0]   virtAddr,
  input  logic [1:0]        cpuMode,
  input  logic              isData,
  output logic [PA_W-1:0]   physAddr,
  output logic              accessFault
);
  tableCmd_t         cmd;
  xlateCfg_t         cfg;
  logic [DATA_W-1:0] parRd, pdrRd;

  reloc_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .regWr(regWr),
    .regAddr(regAddr), .wrBits(regWrData[C0_W-1:0]), .instrDone(instrDone),
    .parRd(parRd), .pdrRd(pdrRd), .regRdData(regRdData), .cmd(cmd), .cfg(cfg)
  );

  reloc_dp #(.VA_W(VA_W), .DATA_W(DATA_W), .PA_W(PA_W), .NARROW_W(NARROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(regWrData), .cfg(cfg),
    .virtAddr(virtAddr), .cpuMode(cpuMode), .isData(isData),
    .parRd(parRd), .pdrRd(pdrRd), .physAddr(physAddr), .accessFault(accessFault)
  );
endmodule

// File: tb/seg_reloc_unit_bench.sv
module seg_reloc_unit_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        busReset = 0;
  logic        regWr = 0;
  logic [7:0]  regAddr = 0;
  logic [15:0] regWrData = 0;
  logic [15:0] regRdData;
  logic        instrDone = 0;
  logic [15:0] virtAddr = 0;
  logic [1:0]  cpuMode = 0;
  logic        isData = 0;
  logic [21:0] physAddr;
  logic        accessFault;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] parSh [64];
  logic [15:0] pdrSh [64];
  logic [5:0]  c0Sh = 0;
  logic [4:0]  c3Sh = 0;

  always #10 clk = ~clk;

  seg_reloc_unit u_seg_reloc_unit (
    .clk(clk), .rstN(rstN), .busReset(busReset), .regWr(regWr),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .instrDone(instrDone), .virtAddr(virtAddr), .cpuMode(cpuMode),
    .isData(isData), .physAddr(physAddr), .accessFault(accessFault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1;
    @(negedge clk);
    regWr = 0;
    if (a == 8'h80) c0Sh = d[5:0];
    else if (a == 8'h81) c3Sh = d[4:0];
    else if (a[6]) pdrSh[a[5:0]] = d;
    else parSh[a[5:0]] = d;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic drive(input int va, input int mode, input bit dref);
    @(negedge clk);
    virtAddr = 16'(va); cpuMode = 2'(mode); isData = dref;
    #1;
  endtask

  function automatic int slotOf(input int va, input int mode, input bit dref);
    bit dsel;
    dsel = dref && ((mode == 0 && c3Sh[2]) || (mode == 1 && c3Sh[1]) || (mode == 3 && c3Sh[0]));
    return mode * 16 + int'(dsel) * 8 + (va >> 13);
  endfunction

  function automatic logic [21:0] expPa(input int va, input int mode, input bit dref);
    int p, s;
    if (!c0Sh[0]) return (va >= 'hE000) ? 22'(32'h3FE000 | (va & 'h1FFF)) : 22'(va);
    p = int'(parSh[slotOf(va, mode, dref)]);
    if (!c3Sh[3]) p = p & 'hFFF;
    s = p * 64 + (va & 'h1FFF);
    if (!c3Sh[3] && s >= 'h3E000) s = s + 'h3C0000;
    return 22'(s & 'h3FFFFF);
  endfunction

  function automatic logic expFault(input int va, input int mode, input bit dref);
    return c0Sh[0] && (pdrSh[slotOf(va, mode, dref)][2:1] == 2'b00);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int modes [3] = '{0, 1, 3};
    for (int i = 0; i < 64; i++) begin parSh[i] = 0; pdrSh[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;

    // reset state
    rdReg(8'h80, rd); chk("R1 reset ctl", 32'(rd), 0);
    rdReg(8'h81, rd); chk("R2 reset ext", 32'(rd), 0);
    drive('h1234, 0, 0); chk("R5 reset pass", 32'(physAddr), 32'h1234);

    // R1: control word, all 64 writable patterns with junk high bits
    for (int v = 0; v < 64; v++) begin
      instrDone = v[0] ^ v[3];
      wrReg(8'h80, 16'(v) | 16'hFF40);
      rdReg(8'h80, rd);
      chk("R1 ctl readback", 32'(rd), 32'(v | (int'(instrDone) << 7)));
    end
    wrReg(8'h80, 0);

    // R2: extension word
    for (int v = 0; v < 32; v++) begin
      wrReg(8'h81, 16'(v) | 16'hFFE0);
      rdReg(8'h81, rd);
      chk("R2 ext readback", 32'(rd), 32'(v));
    end

    // R4: base and descriptor storage
    for (int i = 0; i < 64; i++) begin
      wrReg(8'(i), 16'((i * 'h1357) ^ 'hA5C3));
      wrReg(8'(i) | 8'h40, 16'(i * 5));
    end
    for (int i = 0; i < 64; i++) begin
      rdReg(8'(i), rd);          chk("R4 base", 32'(rd), 32'(16'((i * 'h1357) ^ 'hA5C3)));
      rdReg(8'(i) | 8'h40, rd);  chk("R4 descr", 32'(rd), 32'(16'(i * 5)));
    end

    // R3: bus reset clears both words, keeps tables
    wrReg(8'h80, 16'h003F);
    wrReg(8'h81, 16'h001F);
    @(negedge clk); busReset = 1;
    @(negedge clk); busReset = 0;
    c0Sh = 0; c3Sh = 0;
    instrDone = 0;
    rdReg(8'h80, rd); chk("R3 ctl cleared", 32'(rd), 0);
    rdReg(8'h81, rd); chk("R3 ext cleared", 32'(rd), 0);
    rdReg(8'h05, rd); chk("R3 table kept", 32'(rd), 32'(parSh[5]));

    // R5: relocation disabled
    for (int va = 0; va < 65536; va += 257) begin
      drive(va, va % 4, va[1]);
      chk("R5 plain map", 32'(physAddr), 32'(expPa(va, va % 4, va[1])));
      chk("R11 no fault off", 32'(accessFault), 0);
    end
    drive('hE000, 0, 0); chk("R5 io first", 32'(physAddr), 32'h3FE000);
    drive('hFFFF, 3, 1); chk("R5 io last", 32'(physAddr), 32'h3FFFFF);
    drive('hDFFF, 1, 0); chk("R5 below io", 32'(physAddr), 32'h00DFFF);

    // R6: identity bases for kernel instruction space
    for (int s = 0; s < 8; s++) wrReg(8'(s), 16'(s * 'h80));
    wrReg(8'h81, 16'h0008);
    wrReg(8'h80, 16'h0001);
    for (int va = 0; va < 65536; va += 'h0105) begin
      drive(va, 0, 0); chk("R6 identity 22", 32'(physAddr), 32'(va));
    end
    wrReg(8'h81, 16'h0000);
    for (int va = 0; va < 'hE000; va += 'h0209) begin
      drive(va, 0, 0); chk("R6 identity 18", 32'(physAddr), 32'(va));
    end

    // R7, R8: narrow mode specifics
    wrReg(8'h07, 16'hFF80);
    drive('hE010, 0, 0); chk("R8 io page", 32'(physAddr), 32'h3FE010);
    wrReg(8'h03, 16'hA123);
    drive('h6004, 0, 0); chk("R7 top bits ignored", 32'(physAddr), 32'h0048C4);
    wrReg(8'h81, 16'h0008);
    drive('h6004, 0, 0); chk("R9 full base", 32'(physAddr), 32'h2848C4);

    // R10: data set chosen only when enabled
    wrReg(8'h0B, 16'h0400);
    wrReg(8'h81, 16'h0000);
    drive('h6004, 0, 1); chk("R10 d off uses I", 32'(physAddr), 32'h0048C4);
    wrReg(8'h81, 16'h0004);
    drive('h6004, 0, 1); chk("R10 d on uses D", 32'(physAddr), 32'h010004);
    drive('h6004, 0, 0); chk("R10 fetch uses I", 32'(physAddr), 32'h0048C4);

    // full sweep: R7/R9/R10/R11 under every extension configuration
    for (int i = 0; i < 64; i++) begin
      wrReg(8'(i), 16'((i * 'h3B1D) ^ 'h5E27));
      wrReg(8'(i) | 8'h40, 16'(i * 3));
    end
    wrReg(8'h80, 16'h0001);
    for (int c = 0; c < 16; c++) begin
      wrReg(8'h81, 16'(c));
      for (int m = 0; m < 3; m++) begin
        for (int d = 0; d < 2; d++) begin
          for (int k = 0; k < 17; k++) begin
            int va;
            va = (k * 'h0F0F + c * 'h11) & 'hFFFF;
            drive(va, modes[m], d[0]);
            chk(d[0] ? "R10 sweep" : (c[3] ? "R9 sweep" : "R7 sweep"),
                32'(physAddr), 32'(expPa(va, modes[m], d[0])));
            chk("R11 fault", 32'(accessFault), 32'(expFault(va, modes[m], d[0])));
          end
        end
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule